// File: doc/BRIEF.md
# I2C Byte-Store Read Target

This block is an I2C target in front of a 256-entry, 8-bit internal store. A host addresses it with a 7-bit device address. The upper four bits of that address are fixed at `1010`, and the lower three come from strap inputs. The block's main job is returning data. There are three ways to read:

- **Random read.** An address-only write loads the internal word pointer, and a repeated START with a read request follows it.
- **Current-address read.** This starts straight from the present pointer value.
- **Sequential read.** Either of the forms above continues for as long as the host acknowledges each byte.

SCL and SDA are oversampled on a fast system clock through two-flop synchronizers. START and STOP are detected from the synchronized samples. The block pulls SDA low through an open-drain style enable, `sda_oe_o`. When this enable is high, the pad must drive low. When it is low, the line is released.

A minimal write path stores one data byte per write transaction, so the store can be filled. The data path in both directions is the I2C bus itself. Back-pressure comes only from the bus protocol: the host paces every bit with SCL, and a host NACK ends a read. The block has no stream handshake pins.

Top module: `i2c_ee_read_target`

## Requirements
- R1: The block ACKs (pulls SDA low during the 9th clock) a device address byte whose upper seven bits equal `1010` followed by `strap_i[2:0]`. Bit 0 of that byte is R/W, where 1 means read. Any other address gets no ACK, and the block then acknowledges nothing and stores nothing until the next START.
- R2: A STOP (SDA rising while SCL is high) in any state returns the block to idle with SDA released. A START (SDA falling while SCL is high) in any state restarts the device address phase.
- R3: In a write transaction, the first byte after the device address is a word address. It loads the pointer and is ACKed. If a repeated START or a STOP follows, no data byte is needed, and the next read starts at that address.
- R4: In a read transaction, the block sends the byte at the pointer MSB first and advances the pointer. Each time the host ACKs, the block sends the byte at the next ascending address.
- R5: The pointer wraps from 255 to 0 during a sequential read.
- R6: A read request given directly after START returns data from the current pointer, which is one past the last byte transferred.
- R7: The block releases SDA during the host's acknowledge slot of every read byte. After a host NACK, it drives nothing until the next START.
- R8: In a write transaction, the first byte after the word address is stored at the pointer, ACKed, and the pointer advances. Any later data bytes in the same transaction are NACKed and not stored.
- R9: `sda_oe_o` changes only while synchronized SCL is low, so data and ACK bits stay stable through the SCL high phase.
- R10: After reset, SDA is released and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL phases must each last at least four cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Low three bits of the device address |
| scl_i | input | 1 | Bus clock as seen on the pad |
| sda_i | input | 1 | Bus data as seen on the pad |
| sda_oe_o | output | 1 | High pulls SDA low; low releases it |

## Verification
A scoreboard tracks the store's contents through a bench-side model. The bench then runs several read patterns against it:
- A random read that starts mid-store tells the loaded address apart from the old pointer.
- A follow-on current-address read shows that the pointer ends one past the last byte sent.
- A sequential read across address 255 shows the wrap to 0.
- A write carrying only an address, closed by STOP, shows the pointer is loaded with no data byte.

Further patterns cover the negative cases. These are a foreign device address, a second data byte in one write, and a host NACK, each checked for what the block must not do. The same read forms repeated after a strap change and after reset show address matching and the reset pointer.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WA,
    ST_WA_ACK,
    ST_WD,
    ST_WD_ACK,
    ST_RD,
    ST_RD_ACK
  } ee_state_t;

  localparam logic [3:0] DEV_PREFIX = 4'b1010;
endpackage

// File: rtl/i2cee_line_sync.sv
module i2cee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cee_byte_array.sv
module i2cee_byte_array #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_ee_read_target.sv
module i2c_ee_read_target
  import i2cee_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] strap_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o
);
  localparam int BCW = $clog2(DW);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(DW - 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  ee_state_t state;
  logic [DW-1:0]  sr, txsr, rd_data;
  logic [BCW-1:0] bitcnt;
  logic           got8, rw, hostack, sda_oe_q, we;
  logic [AW-1:0]  ptr;

  i2cee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  assign we = (state == ST_WD) && scl_fall && got8 && !start_det && !stop_det;

  i2cee_byte_array #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .we(we), .waddr(ptr), .wdata(sr),
    .raddr(ptr), .rdata(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sr       <= '0;
      txsr     <= '0;
      bitcnt   <= '0;
      got8     <= 1'b0;
      rw       <= 1'b0;
      hostack  <= 1'b0;
      sda_oe_q <= 1'b0;
      ptr      <= '0;
    end else if (start_det) begin
      state    <= ST_DEV;
      bitcnt   <= '0;
      got8     <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      got8     <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_WA, ST_WD: begin
          if (scl_rise && !got8) begin
            sr     <= {sr[DW-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == LAST_BIT) got8 <= 1'b1;
          end else if (scl_fall && got8) begin
            got8   <= 1'b0;
            bitcnt <= '0;
            if (state == ST_DEV) begin
              if (sr[DW-1:1] == {DEV_PREFIX, strap_i}) begin
                rw       <= sr[0];
                sda_oe_q <= 1'b1;
                state    <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_WA) begin
              ptr      <= sr[AW-1:0];
              sda_oe_q <= 1'b1;
              state    <= ST_WA_ACK;
            end else begin
              ptr      <= ptr + 1'b1;
              sda_oe_q <= 1'b1;
              state    <= ST_WD_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (rw) begin
              txsr     <= rd_data;
              sda_oe_q <= ~rd_data[DW-1];
              ptr      <= ptr + 1'b1;
              state    <= ST_RD;
            end else begin
              sda_oe_q <= 1'b0;
              state    <= ST_WA;
            end
          end
        end
        ST_WA_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            state    <= ST_WD;
          end
        end
        ST_WD_ACK: begin
          if (scl_fall) begin
            sda_oe_q <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe_q <= 1'b0;
              state    <= ST_RD_ACK;
            end else begin
              bitcnt   <= bitcnt + 1'b1;
              txsr     <= {txsr[DW-2:0], 1'b0};
              sda_oe_q <= ~txsr[DW-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            hostack <= ~sda_s;
          end else if (scl_fall) begin
            bitcnt <= '0;
            if (hostack) begin
              txsr     <= rd_data;
              sda_oe_q <= ~rd_data[DW-1];
              ptr      <= ptr + 1'b1;
              state    <= ST_RD;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = sda_oe_q;

  // R9: the enable moves only after a sample that saw SCL low
  a_r9_sda_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(scl_s) && !$past(start_det) && !$past(stop_det)) |-> $stable(sda_oe_q));

  // R2: STOP always lands in idle with SDA released
  a_r2_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe_q));

  // R7: host NACK ends the read and releases the line
  a_r7_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK && scl_fall && !hostack && !start_det && !stop_det)
    |=> (state == ST_IDLE && !sda_oe_q));

  // R5: each acknowledged byte steps the pointer by one, modulo the depth
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK && scl_fall && hostack && !start_det && !stop_det)
    |=> (ptr == AW'($past(ptr) + 1'b1)));

  // R8: a stored byte is always followed by the block's ACK
  a_r8_store_acked: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (state == ST_WD_ACK && sda_oe_q));
endmodule

// File: tb/test_i2c_ee_read_target.sv
module test_i2c_ee_read_target;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] strap = 3'b000;
  logic scl = 1'b1;
  logic sda_h = 1'b1;
  logic sda_oe;
  logic sda_line;

  int vectors = 0;
  int fails = 0;
  int r9_viol = 0;
  logic [7:0] mdl [256];
  logic [7:0] exp_q [$];
  string tag_q [$];
  logic [7:0] mon_byte;
  event mon_ev;
  logic oe_prev = 1'b0;
  logic scl_prev = 1'b1;

  always #5 clk = ~clk;
  assign sda_line = sda_h & ~sda_oe;

  i2c_ee_read_target i_i2c_ee_read_target (
    .clk(clk), .rst_n(rst_n), .strap_i(strap),
    .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  // R9 monitor: the enable must not move while the bus clock is high
  always @(negedge clk) begin
    if (rst_n && scl && scl_prev && sda_oe != oe_prev) r9_viol++;
    scl_prev <= scl;
    oe_prev  <= sda_oe;
  end

  // scoreboard monitor
  initial forever begin
    @(mon_ev);
    if (exp_q.size() == 0) begin
      chk(0, "unexpected byte", mon_byte, 0);
    end else begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(mon_byte == e, t, mon_byte, e);
    end
  end

  task automatic push(input logic [7:0] b, input string t);
    exp_q.push_back(b);
    tag_q.push_back(t);
  endtask

  task automatic bus_start();
    sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_rstart();
    sda_h = 1'b1; wq(); scl = 1'b1; wq(); sda_h = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; wq(); scl = 1'b1; wq(); sda_h = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string tag);
    logic got;
    for (int i = 7; i >= 0; i--) begin
      sda_h = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
    end
    sda_h = 1'b1; wq(); scl = 1'b1; wq();
    got = ~sda_line;
    wq(); scl = 1'b0; wq();
    chk(got == exp_ack, tag, got, exp_ack);
  endtask

  task automatic recv_byte(input logic ack);
    logic [7:0] b;
    b = '0;
    sda_h = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1'b1; wq();
      b = {b[6:0], sda_line};
      wq(); scl = 1'b0;
    end
    wq();
    sda_h = ~ack; wq(); scl = 1'b1; wq();
    if (!ack) chk(sda_line == 1'b1, "R7 host-ack slot released", sda_line, 1);
    wq(); scl = 1'b0; wq(); sda_h = 1'b1;
    mon_byte = b;
    ->mon_ev;
  endtask

  function automatic logic [7:0] dev(input logic [2:0] s, input logic r);
    return {4'b1010, s, r};
  endfunction

  task automatic write1(input logic [7:0] a, input logic [7:0] d);
    bus_start();
    send_byte(dev(strap, 1'b0), 1'b1, "R1 device ack");
    send_byte(a, 1'b1, "R3 word address ack");
    send_byte(d, 1'b1, "R8 data ack");
    bus_stop();
    mdl[a] = d;
  endtask

  task automatic read_run(input int n, input string t);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    bus_stop();
    wq();
    chk(sda_oe == 1'b0, "R2 released after stop", sda_oe, 0);
    chk(exp_q.size() == 0, {t, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  task automatic random_read(input logic [7:0] a, input int n, input string t);
    bus_start();
    send_byte(dev(strap, 1'b0), 1'b1, "R1 device ack");
    send_byte(a, 1'b1, "R3 word address ack");
    bus_rstart();
    send_byte(dev(strap, 1'b1), 1'b1, "R1 read ack");
    for (int i = 0; i < n; i++) push(mdl[8'(a + i)], t);
    read_run(n, t);
  endtask

  task automatic current_read(input logic [7:0] a, input int n, input string t);
    bus_start();
    send_byte(dev(strap, 1'b1), 1'b1, "R1 read ack");
    for (int i = 0; i < n; i++) push(mdl[8'(a + i)], t);
    read_run(n, t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wq();
    chk(sda_oe == 1'b0, "R10 reset releases SDA", sda_oe, 0);

    // fill the store
    for (int a = 0; a < 4; a++) write1(8'(a), 8'(a * 37 + 11));
    for (int a = 100; a < 105; a++) write1(8'(a), 8'(a * 37 + 11));
    for (int a = 250; a < 256; a++) write1(8'(a), 8'(a * 37 + 11));

    // R3 R4: random read, ascending
    random_read(8'd100, 3, "R4 sequential byte");
    // R6: current address continues at 103
    current_read(8'd103, 2, "R6 current address");
    // R5: wrap across the top
    random_read(8'd253, 5, "R5 wrap");

    // R3: address-only write closed by STOP sets the pointer
    bus_start();
    send_byte(dev(strap, 1'b0), 1'b1, "R1 device ack");
    send_byte(8'd250, 1'b1, "R3 word address ack");
    bus_stop();
    current_read(8'd250, 1, "R3 address-only write");

    // R1: foreign device address is NACKed and ignored
    bus_start();
    send_byte(dev(3'b101, 1'b0), 1'b0, "R1 foreign address nack");
    send_byte(8'd0, 1'b0, "R1 ignored word byte");
    send_byte(8'hEE, 1'b0, "R1 ignored data byte");
    bus_stop();
    random_read(8'd0, 1, "R1 store untouched");

    // R8: second data byte NACKed and not stored
    bus_start();
    send_byte(dev(strap, 1'b0), 1'b1, "R1 device ack");
    send_byte(8'd2, 1'b1, "R3 word address ack");
    send_byte(8'h77, 1'b1, "R8 first data ack");
    send_byte(8'h99, 1'b0, "R8 second data nack");
    bus_stop();
    mdl[2] = 8'h77;
    random_read(8'd2, 2, "R8 single byte stored");

    // R1: strap change moves the matched address
    strap = 3'b011;
    wq();
    random_read(8'd101, 2, "R1 strap match");

    // R10: reset returns the pointer to 0
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wq();
    current_read(8'd0, 2, "R10 pointer after reset");

    chk(r9_viol == 0, "R9 SDA steady while SCL high", r9_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule